// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Selectable Write Policy and RAM Partition

This block is a direct-mapped data cache controller. It sits between a processor load/store port and a simple word-wide external memory bus. Each line is 32 bytes. The default array holds 512 lines. Every address maps to exactly one line, chosen by the address bits just above the line offset. The block keeps a tag, a valid bit and a dirty bit for each line, next to the line data. A miss is served with whole-line bursts on the external bus: the victim is written out first when it is dirty, then the new line is read in. The processor waits on `cpu_ready` for as long as the miss takes.

Two configuration bits are loaded through `cfg_load`, and both reset to zero. The first bit picks the write policy. In copy-back, stores stay in the line and mark it dirty. In write-through, each store also goes out as a single-word write, and a store miss does not allocate a line. The second bit gives the upper half of the storage to a directly addressed RAM. That RAM answers an 8 KB address window with no tag check and no bus traffic. The cache then runs on the lower 256 lines.

Software must invalidate and flush the cache before it changes either bit. The hardware does no flush of its own. In the bench, a reset stands in for that flush.

Top module: `opc_cache`

## Requirements
- R1: A read hit is accepted while `cpu_ready` is high. One cycle later `rsp_valid` pulses with the stored word, and the hit causes no external bus activity.
- R2: A read miss on a clean or invalid line issues one 8-beat read burst (`mem_burst`=1, `mem_we`=0). The burst starts at the line base and steps through word offsets 0 to 7 in ascending order. The response then carries the requested word.
- R3: In copy-back mode, a store hit updates the line and marks it dirty with no bus activity, so external memory keeps its old value.
- R4: A miss whose victim line is valid and dirty first writes the victim out as an 8-beat write burst to the victim's own line address. The fill burst follows, and afterwards external memory holds the stored data.
- R5: In write-through mode, every store is sent as one single-beat write (`mem_burst`=0) before its response. A store hit also updates the cached line, so a later read hits with the new data.
- R6: In write-through mode, a store miss does not allocate a line. A later read of the same address therefore misses and fills.
- R7: In RAM mode, an access whose address bits [31:13] equal the parameter `RAM_BASE` (default 0x3E000, so 0x7C00_0000 to 0x7C00_1FFF) reads or writes the RAM half. It makes no tag check and no bus access, and cache fills never disturb it.
- R8: In RAM mode, the cache index is address bits [12:5] over 256 lines, so two addresses that differ only in bit 13 evict each other. In full mode the index is bits [13:5], and the same two addresses can both stay resident.
- R9: `cpu_ready` stays low from the cycle after a miss or write-through store is accepted until that access completes. A request raised while `cpu_ready` is low is ignored and gets no response.
- R10: After reset, no line is valid, `cpu_ready` is high, `mem_req` is low, and the block runs copy-back with the full cache whatever the configuration inputs show. New configuration takes effect only on a `cfg_load` pulse while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Loads the two configuration bits when idle |
| cfg_write_through | input | 1 | 1 selects write-through, 0 copy-back |
| cfg_ram_mode | input | 1 | 1 turns half the storage into RAM |
| cpu_req | input | 1 | Access request, taken when `cpu_ready` is high |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | 32 | Byte address (word aligned) |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load data (zero for stores) |
| mem_req | output | 1 | External bus request, held for every beat |
| mem_we | output | 1 | External write |
| mem_burst | output | 1 | Beat belongs to an 8-beat line burst |
| mem_addr | output | 32 | External word address |
| mem_wdata | output | 32 | External write data |
| mem_rdata | input | 32 | External read data |
| mem_ack | input | 1 | Beat accepted this cycle |

## Verification
The hardest case to reach is a dirty eviction followed by a fill. It needs a store to allocate and dirty a line, then a read of another address that lands on the same index. The stimulus makes that pairing on purpose, with addresses 16 KB apart. A second tricky case is the RAM-mode index overlap. A RAM word is written at the same low index bits as two cacheable addresses that differ only in bit 13. Those two addresses are read alternately to force conflict misses, and the RAM word is then read back to show the fills never touched it. To show that a request during a stall is ignored, a store is raised in the middle of a miss. The bench then confirms that no extra response appears and that a later read returns the old value.

// File: rtl/opc_pkg.sv
package opc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WBACK,
        ST_FILL,
        ST_REPLAY,
        ST_WTWR
    } opc_state_e;

endpackage

// File: rtl/opc_addr_map.sv
module opc_addr_map #(
    parameter int ADDR_W   = 32,
    parameter int OFF_W    = 5,
    parameter int IDX_W    = 9,
    parameter int BYTE_W   = 2,
    parameter int RAM_BASE = 'h3E000,
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W + 1,
    localparam int BEAT_W  = OFF_W - BYTE_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ram_mode,
    output logic              in_ram,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag,
    output logic [BEAT_W-1:0] word
);
    logic unused_low;
    assign unused_low = ^addr[BYTE_W-1:0];

    assign tag    = addr[ADDR_W-1 -: TAG_W];
    assign word   = addr[OFF_W-1:BYTE_W];
    assign in_ram = ram_mode && (tag == TAG_W'(RAM_BASE));

    always_comb begin
        if (ram_mode) idx = {in_ram, addr[OFF_W+IDX_W-2:OFF_W]};
        else          idx = addr[OFF_W+IDX_W-1:OFF_W];
    end
endmodule

// File: rtl/opc_line_store.sv
module opc_line_store #(
    parameter int LINES  = 512,
    parameter int WPL    = 8,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 19,
    localparam int IDX_W  = $clog2(LINES),
    localparam int BEAT_W = $clog2(WPL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    input  logic [BEAT_W-1:0] a_word,
    output logic [DATA_W-1:0] a_data,
    output logic [TAG_W-1:0]  a_tag,
    output logic              a_valid,
    output logic              a_dirty,
    input  logic [IDX_W-1:0]  b_idx,
    input  logic [BEAT_W-1:0] b_word,
    output logic [DATA_W-1:0] b_data,
    input  logic              d_we,
    input  logic [IDX_W-1:0]  d_idx,
    input  logic [BEAT_W-1:0] d_word,
    input  logic [DATA_W-1:0] d_wdata,
    input  logic              m_we,
    input  logic [IDX_W-1:0]  m_idx,
    input  logic [TAG_W-1:0]  m_tag,
    input  logic              m_valid,
    input  logic              m_dirty
);
    logic [DATA_W-1:0] data_q [LINES*WPL];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [LINES-1:0]  valid_q;
    logic [LINES-1:0]  dirty_q;

    assign a_data  = data_q[{a_idx, a_word}];
    assign b_data  = data_q[{b_idx, b_word}];
    assign a_tag   = tag_q[a_idx];
    assign a_valid = valid_q[a_idx];
    assign a_dirty = dirty_q[a_idx];

    always_ff @(posedge clk) begin
        if (d_we) data_q[{d_idx, d_word}] <= d_wdata;
    end

    always_ff @(posedge clk) begin
        if (m_we) tag_q[m_idx] <= m_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (m_we) begin
            valid_q[m_idx] <= m_valid;
            dirty_q[m_idx] <= m_dirty;
        end
    end
endmodule

// File: rtl/opc_cache.sv
module opc_cache
    import opc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int LINES      = 512,
    parameter int RAM_BASE   = 'h3E000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              cfg_write_through,
    input  logic              cfg_ram_mode,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_burst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int WPL    = LINE_BYTES / (DATA_W / 8);
    localparam int BEAT_W = $clog2(WPL);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W + 1;
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(WPL - 1);

    typedef struct packed {
        opc_state_e        state;
        logic [BEAT_W-1:0] beat;
        logic              wt;
        logic              ram;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic [LINE_W-1:0] victim;
        logic              rsp_valid;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_q, r_d;

    logic              c_ram, l_ram;
    logic [IDX_W-1:0]  c_idx, l_idx, a_idx;
    logic [TAG_W-1:0]  c_tag, l_tag, a_tag;
    logic [BEAT_W-1:0] c_word, l_word, a_word;
    logic [DATA_W-1:0] a_data, b_data;
    logic              a_valid, a_dirty;
    logic              d_we, m_we, m_valid, m_dirty;
    logic [IDX_W-1:0]  d_idx, m_idx;
    logic [BEAT_W-1:0] d_word;
    logic [DATA_W-1:0] d_wdata;
    logic [TAG_W-1:0]  m_tag;
    logic              hit_c;
    logic              unused_lram;

    opc_addr_map #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .BYTE_W(BYTE_W),
                   .RAM_BASE(RAM_BASE)) i_map_cpu (
        .addr(cpu_addr), .ram_mode(r_q.ram), .in_ram(c_ram),
        .idx(c_idx), .tag(c_tag), .word(c_word));

    opc_addr_map #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .BYTE_W(BYTE_W),
                   .RAM_BASE(RAM_BASE)) i_map_held (
        .addr(r_q.addr), .ram_mode(r_q.ram), .in_ram(l_ram),
        .idx(l_idx), .tag(l_tag), .word(l_word));

    assign unused_lram = l_ram;

    opc_line_store #(.LINES(LINES), .WPL(WPL), .DATA_W(DATA_W), .TAG_W(TAG_W)) i_store (
        .clk(clk), .rst_n(rst_n),
        .a_idx(a_idx), .a_word(a_word), .a_data(a_data), .a_tag(a_tag),
        .a_valid(a_valid), .a_dirty(a_dirty),
        .b_idx(l_idx), .b_word(r_q.beat), .b_data(b_data),
        .d_we(d_we), .d_idx(d_idx), .d_word(d_word), .d_wdata(d_wdata),
        .m_we(m_we), .m_idx(m_idx), .m_tag(m_tag), .m_valid(m_valid), .m_dirty(m_dirty));

    assign a_idx  = (r_q.state == ST_IDLE) ? c_idx  : l_idx;
    assign a_word = (r_q.state == ST_IDLE) ? c_word : l_word;
    assign hit_c  = a_valid && (a_tag == c_tag);

    always_comb begin
        r_d          = r_q;
        r_d.rsp_valid = 1'b0;
        d_we = 1'b0; d_idx = l_idx; d_word = l_word; d_wdata = r_q.wdata;
        m_we = 1'b0; m_idx = l_idx; m_tag = l_tag; m_valid = 1'b1; m_dirty = 1'b0;
        mem_req = 1'b0; mem_we = 1'b0; mem_burst = 1'b0;
        mem_addr = '0; mem_wdata = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cfg_load) begin
                    r_d.wt  = cfg_write_through;
                    r_d.ram = cfg_ram_mode;
                end
                if (cpu_req) begin
                    r_d.addr  = cpu_addr;
                    r_d.we    = cpu_we;
                    r_d.wdata = cpu_wdata;
                    r_d.rdata = '0;
                    d_idx = c_idx; d_word = c_word; d_wdata = cpu_wdata;
                    m_idx = c_idx; m_tag = c_tag;
                    if (c_ram || hit_c) begin
                        d_we = cpu_we;
                        if (!cpu_we) r_d.rdata = a_data;
                        if (!c_ram && cpu_we && r_q.wt) begin
                            r_d.state = ST_WTWR;
                        end else begin
                            r_d.rsp_valid = 1'b1;
                            if (!c_ram && cpu_we) begin
                                m_we    = 1'b1;
                                m_dirty = 1'b1;
                            end
                        end
                    end else if (cpu_we && r_q.wt) begin
                        r_d.state = ST_WTWR;
                    end else begin
                        r_d.victim = {a_tag, c_idx[IDX_W-2:0]};
                        r_d.beat   = '0;
                        r_d.state  = (a_valid && a_dirty) ? ST_WBACK : ST_FILL;
                    end
                end
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_burst = 1'b1;
                mem_addr  = {r_q.victim, r_q.beat, {BYTE_W{1'b0}}};
                mem_wdata = b_data;
                if (mem_ack) begin
                    r_d.beat = r_q.beat + 1'b1;
                    if (r_q.beat == LAST_BEAT) r_d.state = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req   = 1'b1;
                mem_burst = 1'b1;
                mem_addr  = {r_q.addr[ADDR_W-1:OFF_W], r_q.beat, {BYTE_W{1'b0}}};
                if (mem_ack) begin
                    d_we     = 1'b1;
                    d_word   = r_q.beat;
                    d_wdata  = mem_rdata;
                    r_d.beat = r_q.beat + 1'b1;
                    if (r_q.beat == LAST_BEAT) begin
                        m_we      = 1'b1;
                        r_d.state = ST_REPLAY;
                    end
                end
            end
            ST_REPLAY: begin
                r_d.rsp_valid = 1'b1;
                r_d.state     = ST_IDLE;
                if (r_q.we) begin
                    d_we    = 1'b1;
                    m_we    = 1'b1;
                    m_dirty = 1'b1;
                end else begin
                    r_d.rdata = a_data;
                end
            end
            ST_WTWR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {r_q.addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
                mem_wdata = r_q.wdata;
                if (mem_ack) begin
                    r_d.rsp_valid = 1'b1;
                    r_d.state     = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_ready = (r_q.state == ST_IDLE);
    assign rsp_valid = r_q.rsp_valid;
    assign rsp_rdata = r_q.rdata;

    assert_stall_on_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    assert_ram_no_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && c_ram) |=> (!mem_req && rsp_valid));

    assert_burst_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && mem_burst) |-> (mem_addr[OFF_W-1:0] == '0));

    assert_wt_never_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_we && r_q.wt) |-> !m_dirty);

    assert_evict_then_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_burst && mem_ack && r_q.beat == LAST_BEAT)
        |=> (mem_req && !mem_we && mem_burst));

    assert_single_wt_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_burst && mem_ack) |=> (rsp_valid && !mem_req));
endmodule

// File: tb/test_opc_cache.sv
`timescale 1ns/1ps
module test_opc_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0, cfg_write_through = 1'b0, cfg_ram_mode = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready, rsp_valid, mem_req, mem_we, mem_burst;
    logic [31:0] rsp_rdata, mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    always #2.5 clk = ~clk;

    opc_cache i_opc_cache (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_write_through(cfg_write_through), .cfg_ram_mode(cfg_ram_mode),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_burst(mem_burst), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

    int compared = 0, mismatched = 0;
    int rd_beats = 0, wr_beats = 0, single_wr = 0, seq_err = 0;
    logic [2:0] tb_beat = '0;
    logic [31:0] ext    [logic [31:0]];
    logic [31:0] golden [logic [31:0]];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    function automatic logic [31:0] dflt(input logic [31:0] a);
        return a ^ 32'hC0DE_0000;
    endfunction
    function automatic logic [31:0] ext_rd(input logic [31:0] a);
        return ext.exists(a) ? ext[a] : dflt(a);
    endfunction
    function automatic logic [31:0] gold_rd(input logic [31:0] a);
        return golden.exists(a) ? golden[a] : dflt(a);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // external memory responder: one beat per cycle
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            mem_ack = 1'b1;
            if (mem_burst) begin
                if (mem_addr[4:2] != tb_beat) seq_err++;
                tb_beat = tb_beat + 3'd1;
            end
            if (mem_we) begin
                ext[mem_addr] = mem_wdata;
                if (mem_burst) wr_beats++; else single_wr++;
            end else begin
                mem_rdata = ext_rd(mem_addr);
                rd_beats++;
            end
        end else begin
            mem_ack = 1'b0;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                compared++; mismatched++;
                $display("FAIL R9: unexpected response actual %h expected none", rsp_rdata);
            end else begin
                check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic access(input string req, input logic we, input logic [31:0] a,
                          input logic [31:0] d);
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        if (we) begin golden[a] = d; exp_q.push_back(32'h0); end
        else exp_q.push_back(gold_rd(a));
        tag_q.push_back(req);
        @(negedge clk);
        cpu_req = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic bus(input string req, input int r0, input int w0, input int s0,
                       input int dr, input int dw, input int ds);
        check({req, " read beats"},  32'(rd_beats - r0),  32'(dr));
        check({req, " burst writes"}, 32'(wr_beats - w0), 32'(dw));
        check({req, " single writes"}, 32'(single_wr - s0), 32'(ds));
    endtask

    task automatic restart(input logic wt, input logic ram);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cfg_load = 1'b1; cfg_write_through = wt; cfg_ram_mode = ram;
        @(negedge clk); cfg_load = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        int r0, w0, s0;
        cfg_write_through = 1'b1; cfg_ram_mode = 1'b1;   // not loaded
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 ready after reset", 32'(cpu_ready), 32'd1);
        check("R10 no bus after reset", 32'(mem_req), 32'd0);

        // R10: still copy-back, full cache: store miss allocates, no single write
        r0 = rd_beats; w0 = wr_beats; s0 = single_wr;
        access("R10 store miss", 1'b1, 32'h0000_0800, 32'h1111_0001);
        bus("R10", r0, w0, s0, 8, 0, 0);
        r0 = rd_beats; w0 = wr_beats; s0 = single_wr;
        access("R4 evict read", 1'b0, 32'h0000_4800, 32'h0);
        bus("R4 evict", r0, w0, s0, 8, 8, 0);
        check("R4 victim in memory", ext_rd(32'h0000_0800), 32'h1111_0001);

        // R2 / R1
        r0 = rd_beats; w0 = wr_beats; s0 = single_wr;
        access("R2 read miss", 1'b0, 32'h0000_100C, 32'h0);
        bus("R2", r0, w0, s0, 8, 0, 0);
        r0 = rd_beats;
        access("R1 read hit", 1'b0, 32'h0000_100C, 32'h0);
        access("R1 read hit other word", 1'b0, 32'h0000_101C, 32'h0);
        bus("R1", r0, w0, s0, 0, 0, 0);

        // R3
        r0 = rd_beats; w0 = wr_beats; s0 = single_wr;
        access("R3 store hit", 1'b1, 32'h0000_100C, 32'hABCD_0003);
        bus("R3", r0, w0, s0, 0, 0, 0);
        check("R3 memory untouched", ext_rd(32'h0000_100C), dflt(32'h0000_100C));
        access("R3 read back", 1'b0, 32'h0000_100C, 32'h0);

        // R4: same index 16 KB away
        r0 = rd_beats; w0 = wr_beats; s0 = single_wr;
        access("R4 conflict read", 1'b0, 32'h0000_5004, 32'h0);
        bus("R4", r0, w0, s0, 8, 8, 0);
        check("R4 written back", ext_rd(32'h0000_100C), 32'hABCD_0003);

        // R8 full mode: bit-13 neighbours coexist
        access("R8 full E", 1'b0, 32'h0000_0040, 32'h0);
        access("R8 full F", 1'b0, 32'h0000_2040, 32'h0);
        r0 = rd_beats; w0 = wr_beats; s0 = single_wr;
        access("R8 full E again", 1'b0, 32'h0000_0040, 32'h0);
        bus("R8 full", r0, w0, s0, 0, 0, 0);

        // R9: request during stall is ignored
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 32'h0000_3000;
        exp_q.push_back(gold_rd(32'h0000_3000)); tag_q.push_back("R9 miss data");
        @(negedge clk); cpu_req = 1'b0;
        check("R9 ready low in miss", 32'(cpu_ready), 32'd0);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 32'h0000_100C; cpu_wdata = 32'hDEAD_BEEF;
        @(negedge clk); cpu_req = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        access("R9 ignored store left no trace", 1'b0, 32'h0000_100C, 32'h0);

        // write-through mode
        restart(1'b1, 1'b0);
        access("R5 fill", 1'b0, 32'h0000_1000, 32'h0);
        r0 = rd_beats; w0 = wr_beats; s0 = single_wr;
        access("R5 store hit", 1'b1, 32'h0000_1000, 32'h5555_0005);
        bus("R5", r0, w0, s0, 0, 0, 1);
        check("R5 memory updated", ext_rd(32'h0000_1000), 32'h5555_0005);
        access("R5 read hit new data", 1'b0, 32'h0000_1000, 32'h0);
        bus("R5 hit after store", r0, w0, s0, 0, 0, 1);
        r0 = rd_beats; w0 = wr_beats; s0 = single_wr;
        access("R6 store miss", 1'b1, 32'h0000_2000, 32'h6666_0006);
        bus("R6 no allocate", r0, w0, s0, 0, 0, 1);
        check("R6 memory updated", ext_rd(32'h0000_2000), 32'h6666_0006);
        r0 = rd_beats;
        access("R6 read misses", 1'b0, 32'h0000_2000, 32'h0);
        bus("R6 fill", r0, w0, s0, 8, 0, 1);

        // RAM mode
        restart(1'b0, 1'b1);
        r0 = rd_beats; w0 = wr_beats; s0 = single_wr;
        access("R7 ram store", 1'b1, 32'h7C00_0040, 32'h7777_0007);
        access("R7 ram store 2", 1'b1, 32'h7C00_1FFC, 32'h7777_1FFC);
        access("R7 ram load", 1'b0, 32'h7C00_0040, 32'h0);
        bus("R7", r0, w0, s0, 0, 0, 0);
        check("R7 external untouched", 32'(ext.exists(32'h7C00_0040)), 32'd0);
        access("R8 ram-mode E", 1'b0, 32'h0000_0040, 32'h0);
        access("R8 ram-mode F", 1'b0, 32'h0000_2040, 32'h0);
        r0 = rd_beats; w0 = wr_beats; s0 = single_wr;
        access("R8 ram-mode E conflict", 1'b0, 32'h0000_0040, 32'h0);
        bus("R8 conflict", r0, w0, s0, 8, 0, 0);
        access("R7 ram survives fills", 1'b0, 32'h7C00_0040, 32'h0);
        access("R7 ram top word", 1'b0, 32'h7C00_1FFC, 32'h0);

        check("R2 burst beat order", 32'(seq_err), 32'd0);
        check("R9 no stray responses", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule